// File: doc/BRIEF.md
# Up/Down Center-Aligned Timer Counter

This block is a 16-bit timer counter with a small register port. It counts up to a reload limit, counts down from it, or swings between zero and the limit (center-aligned). Each pass through a turning point raises a one-cycle update event. Per-channel compare flags pulse when the count lands on a channel's compare value. In the center-aligned modes, which counting direction may raise those flags depends on the mode.

Software programs a control word and a reload limit through the write port, and reads back the control word, the reload value and the live count. The reload limit can be applied at once, or held in a shadow copy that takes effect at the next update event. A one-pulse option stops the counter at its first update event. A free-running prescaler produces a sampling enable at a selectable fraction of the timer clock.

Top module: `updn_timer`

## Requirements
- R1: After a synchronous reset the control word (address 0) reads 0x0000, the reload value (address 1) reads 0xFFFF, the count (address 2) is 0, and the update event and all compare flags are low.
- R2: The division field (control bits 9:8) makes `smp_en` pulse once every 1 (code 00), 2 (code 01) or 4 (code 10) clock cycles, from a prescaler that runs whether or not the counter is enabled.
- R3: With mode 00 (control bits 6:5), direction bit 4 low and enable bit 0 set, the count rises by one per clock. From a value at or above the active limit it wraps to 0, and `upd_evt` is high in the cycle that shows the 0.
- R4: With mode 00 and direction bit 4 high, the count falls by one per clock. From 0 it reloads the active limit, and `upd_evt` is high in the cycle that shows the limit.
- R5: With modes 01, 10 or 11 the count climbs from 0 to the limit and descends back to 0, giving a period of twice the limit. `upd_evt` is high in the cycle the count reaches the limit and in the cycle it reaches 0.
- R6: A compare flag pulses in the cycle that shows a count equal to that channel's compare value. In mode 00 this happens in either direction. In mode 01 only steps going down may raise it, in mode 10 only steps going up, and in mode 11 steps in both directions.
- R7: A control write that would move the mode from 00 to a non-zero code while the enable bit is set is discarded entirely. The control word and the counting are unchanged.
- R8: In modes 01, 10 and 11, bit 4 of the control read shows the present counting direction (1 while descending). In mode 00 it shows the stored direction bit.
- R9: With one-pulse bit 3 set, the enable bit clears itself at the edge that produces the update event. The count then stays where that edge left it.
- R10: With preload bit 7 clear, a write to the reload value changes the limit used by the counter from the next clock edge.
- R11: With preload bit 7 set, a reload write only updates the shadow copy (which address 1 reads back). The counter keeps the old limit until an update event copies the shadow in.
- R12: Control bits 15:10 and 2:1 always read as 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 reload |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 reload, 2 count |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| cmp_val | input | NCH*WIDTH | Compare values, channel 0 in the low bits |
| count | output | WIDTH | Live counter value |
| upd_evt | output | 1 | One-cycle update event |
| cmp_flag | output | NCH | One-cycle compare flags, one per channel |
| smp_en | output | 1 | Sampling clock enable |

## Verification
Every counting mode is run over reload limits 1 through 6, across several full periods. For each cycle the expected count, update event, compare flags and direction view are computed with modular arithmetic. Sweeping the limit separates an off-by-one at a turning point from a correct period: up and down counting must repeat every limit+1 cycles, and center-aligned counting every twice the limit. Compare values are placed at 1 and at limit-1 so that each is crossed in both directions. The three center-aligned modes are told apart only by which of those crossings raise a flag. Short directed runs cover the cases that hinge on timing: a reload write made mid-count, with and without the shadow copy; the one-pulse stop; a forbidden mode change while running; and the prescaler rates.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

    localparam int REG_W = 16;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;

    typedef enum logic [1:0] {
        MODE_EDGE  = 2'b00,
        MODE_CDOWN = 2'b01,
        MODE_CUP   = 2'b10,
        MODE_CBOTH = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        DIV_BY1 = 2'b00,
        DIV_BY2 = 2'b01,
        DIV_BY4 = 2'b10,
        DIV_RSV = 2'b11
    } smp_div_e;

    typedef struct packed {
        smp_div_e  div;
        logic      preload;
        cnt_mode_e mode;
        logic      down;
        logic      one_pulse;
        logic      run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(logic [REG_W-1:0] w);
        ctrl_t c;
        c.div       = smp_div_e'(w[9:8]);
        c.preload   = w[7];
        c.mode      = cnt_mode_e'(w[6:5]);
        c.down      = w[4];
        c.one_pulse = w[3];
        c.run       = w[0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(ctrl_t c, logic dir_view);
        return {6'b0, c.div, c.preload, c.mode, dir_view, c.one_pulse, 2'b00, c.run};
    endfunction

    function automatic logic is_center(cnt_mode_e m);
        return m != MODE_EDGE;
    endfunction

endpackage

// File: rtl/updn_timer_regs.sv
module updn_timer_regs
    import updn_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             upd_now,
    output ctrl_t            ctrl,
    output logic [WIDTH-1:0] lim_act,
    output logic [WIDTH-1:0] lim_shadow
);

    ctrl_t ctrl_new;
    logic  ctrl_wr;
    logic  rl_wr;
    logic  mode_lock;

    assign ctrl_new  = ctrl_from_word(wr_data);
    assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
    assign rl_wr     = wr_en && (wr_addr == ADDR_RELOAD);
    assign mode_lock = ctrl.run && !is_center(ctrl.mode) && is_center(ctrl_new.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (ctrl_wr && !mode_lock) begin
                ctrl <= ctrl_new;
            end
            if (upd_now && ctrl.one_pulse) begin
                ctrl.run <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_shadow <= '1;
            lim_act    <= '1;
        end else begin
            if (rl_wr) begin
                lim_shadow <= wr_data[WIDTH-1:0];
            end
            if (rl_wr && !ctrl.preload) begin
                lim_act <= wr_data[WIDTH-1:0];
            end else if (upd_now && ctrl.preload) begin
                lim_act <= lim_shadow;
            end
        end
    end

    p_mode_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && ctrl.mode == MODE_EDGE) |=> (ctrl.mode == MODE_EDGE));

    p_one_pulse_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (upd_now && ctrl.one_pulse) |=> !ctrl.run);

    p_shadow_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (ctrl.preload && !upd_now && !rl_wr) |=> $stable(lim_act));

    p_direct_reload_r10: assert property (@(posedge clk) disable iff (rst)
        (rl_wr && !ctrl.preload) |=> (lim_act == $past(wr_data[WIDTH-1:0])));

endmodule

// File: rtl/updn_timer_tick.sv
module updn_timer_tick
    import updn_timer_pkg::*;
#(
    parameter int MAX_DIV_LOG = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  smp_div_e div,
    output logic     smp_en
);

    logic [MAX_DIV_LOG-1:0] psc;

    always_ff @(posedge clk) begin
        if (rst) begin
            psc <= '0;
        end else begin
            psc <= psc + 1'b1;
        end
    end

    always_comb begin
        unique case (div)
            DIV_BY1: smp_en = 1'b1;
            DIV_BY2: smp_en = (psc[0] == 1'b0);
            default: smp_en = (psc[1:0] == 2'b00);
        endcase
    end

    p_div4_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (smp_en && div == DIV_BY4) |=> (!smp_en || div != DIV_BY4));

endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core
    import updn_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  cnt_mode_e        mode,
    input  logic             down_sel,
    input  logic [WIDTH-1:0] lim,
    output logic [WIDTH-1:0] cnt,
    output logic [WIDTH-1:0] cnt_nxt,
    output logic             upd_now,
    output logic             step_dn,
    output logic             cdir,
    output logic             upd_evt
);

    logic             cdir_nxt;
    logic [WIDTH:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_comb begin
        cnt_nxt  = cnt;
        upd_now  = 1'b0;
        step_dn  = 1'b0;
        cdir_nxt = is_center(mode) ? cdir : 1'b0;
        if (run) begin
            if (!is_center(mode)) begin
                if (!down_sel) begin
                    if (cnt >= lim) begin
                        cnt_nxt = '0;
                        upd_now = 1'b1;
                    end else begin
                        cnt_nxt = cnt_inc[WIDTH-1:0];
                    end
                end else begin
                    step_dn = 1'b1;
                    if (cnt == '0) begin
                        cnt_nxt = lim;
                        upd_now = 1'b1;
                    end else begin
                        cnt_nxt = cnt - 1'b1;
                    end
                end
            end else if (!cdir) begin
                if (cnt_inc >= {1'b0, lim}) begin
                    cnt_nxt  = lim;
                    cdir_nxt = 1'b1;
                    upd_now  = 1'b1;
                end else begin
                    cnt_nxt = cnt_inc[WIDTH-1:0];
                end
            end else begin
                step_dn = 1'b1;
                if (cnt <= {{(WIDTH-1){1'b0}}, 1'b1}) begin
                    cnt_nxt  = '0;
                    cdir_nxt = 1'b0;
                    upd_now  = 1'b1;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cdir    <= 1'b0;
            upd_evt <= 1'b0;
        end else begin
            cnt     <= cnt_nxt;
            cdir    <= cdir_nxt;
            upd_evt <= upd_now;
        end
    end

    p_up_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (run && mode == MODE_EDGE && !down_sel && cnt >= lim) |=> (cnt == '0 && upd_evt));

    p_down_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (run && mode == MODE_EDGE && down_sel && cnt == '0) |=> (cnt == $past(lim) && upd_evt));

    p_center_bottom_r5: assert property (@(posedge clk) disable iff (rst)
        (run && mode != MODE_EDGE && cdir && cnt <= 1) |=> (cnt == '0 && !cdir && upd_evt));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(cnt) && !upd_evt));

endmodule

// File: rtl/updn_timer_cmp.sv
module updn_timer_cmp
    import updn_timer_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NCH   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  cnt_mode_e            mode,
    input  logic                 step_dn,
    input  logic [WIDTH-1:0]     cnt_nxt,
    input  logic [NCH*WIDTH-1:0] cmp_val,
    output logic [NCH-1:0]       flag
);

    logic dir_ok;

    always_comb begin
        unique case (mode)
            MODE_CDOWN: dir_ok = step_dn;
            MODE_CUP:   dir_ok = !step_dn;
            default:    dir_ok = 1'b1;
        endcase
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [WIDTH-1:0] ref_val;
        assign ref_val = cmp_val[ch*WIDTH +: WIDTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                flag[ch] <= 1'b0;
            end else begin
                flag[ch] <= run && dir_ok && (cnt_nxt == ref_val);
            end
        end

        p_flag_down_only_r6: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_CDOWN && !step_dn) |=> !flag[ch]);

        p_flag_up_only_r6: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_CUP && step_dn) |=> !flag[ch]);
    end

endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NCH   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [15:0]          wr_data,
    input  logic [1:0]           rd_addr,
    output logic [15:0]          rd_data,
    input  logic [NCH*WIDTH-1:0] cmp_val,
    output logic [WIDTH-1:0]     count,
    output logic                 upd_evt,
    output logic [NCH-1:0]       cmp_flag,
    output logic                 smp_en
);

    ctrl_t            ctrl;
    logic [WIDTH-1:0] lim_act;
    logic [WIDTH-1:0] lim_shadow;
    logic [WIDTH-1:0] cnt_nxt;
    logic             upd_now;
    logic             step_dn;
    logic             cdir;
    logic             dir_view;

    updn_timer_regs #(.WIDTH(WIDTH)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .upd_now    (upd_now),
        .ctrl       (ctrl),
        .lim_act    (lim_act),
        .lim_shadow (lim_shadow)
    );

    updn_timer_tick #(.MAX_DIV_LOG(2)) i_tick (
        .clk    (clk),
        .rst    (rst),
        .div    (ctrl.div),
        .smp_en (smp_en)
    );

    updn_timer_core #(.WIDTH(WIDTH)) i_core (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .mode     (ctrl.mode),
        .down_sel (ctrl.down),
        .lim      (lim_act),
        .cnt      (count),
        .cnt_nxt  (cnt_nxt),
        .upd_now  (upd_now),
        .step_dn  (step_dn),
        .cdir     (cdir),
        .upd_evt  (upd_evt)
    );

    updn_timer_cmp #(.WIDTH(WIDTH), .NCH(NCH)) i_cmp (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .mode    (ctrl.mode),
        .step_dn (step_dn),
        .cnt_nxt (cnt_nxt),
        .cmp_val (cmp_val),
        .flag    (cmp_flag)
    );

    assign dir_view = is_center(ctrl.mode) ? cdir : ctrl.down;

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL:   rd_data = ctrl_to_word(ctrl, dir_view);
            ADDR_RELOAD: rd_data = 16'(lim_shadow);
            ADDR_COUNT:  rd_data = 16'(count);
            default:     rd_data = '0;
        endcase
    end

    p_unused_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_CTRL) |-> (rd_data[15:10] == 6'b0 && rd_data[2:1] == 2'b0));

endmodule

// File: tb/test_updn_timer.sv
module test_updn_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 16;
    localparam int NCH        = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 wr_en = 1'b0;
    logic [1:0]           wr_addr = '0;
    logic [15:0]          wr_data = '0;
    logic [1:0]           rd_addr = '0;
    logic [15:0]          rd_data;
    logic [NCH*WIDTH-1:0] cmp_val = '0;
    logic [WIDTH-1:0]     count;
    logic                 upd_evt;
    logic [NCH-1:0]       cmp_flag;
    logic                 smp_en;

    int n_chk  = 0;
    int n_fail = 0;

    updn_timer #(.WIDTH(WIDTH), .NCH(NCH)) i_updn_timer (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cmp_val  (cmp_val),
        .count    (count),
        .upd_evt  (upd_evt),
        .cmp_flag (cmp_flag),
        .smp_en   (smp_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic allow(int mode, logic dn);
        if (mode == 1) return dn;
        if (mode == 2) return !dn;
        return 1'b1;
    endfunction

    // mode 0..3, dirb for mode 0, limit a, cycles n
    task automatic sweep(int mode, logic dirb, int a, int n);
        int c0, c1;
        logic [15:0] v;
        c0 = 1;
        c1 = (a > 1) ? a - 1 : 0;
        do_reset();
        cmp_val = {WIDTH'(c1), WIDTH'(c0)};
        wr(2'd1, 16'(a));
        wr(2'd0, 16'((mode << 5) | (int'(dirb) << 4) | 1));
        for (int k = 1; k <= n; k++) begin
            int e_cnt, p, m;
            logic e_upd, e_dn, e_dir;
            step();
            if (mode == 0 && !dirb) begin
                e_cnt = k % (a + 1);
                e_upd = (k % (a + 1)) == 0;
                e_dn  = 1'b0;
                e_dir = 1'b0;
                chk("R3 count", int'(count), e_cnt);
                chk("R3 update", int'(upd_evt), int'(e_upd));
            end else if (mode == 0) begin
                m     = k % (a + 1);
                e_cnt = (m == 0) ? 0 : a + 1 - m;
                e_upd = (m == 1);
                e_dn  = 1'b1;
                e_dir = 1'b1;
                chk("R4 count", int'(count), e_cnt);
                chk("R4 update", int'(upd_evt), int'(e_upd));
            end else begin
                p     = k % (2 * a);
                e_cnt = (p <= a) ? p : 2 * a - p;
                e_upd = (k % a) == 0;
                e_dn  = (p == 0) || (p > a);
                e_dir = (p >= a);
                chk("R5 count", int'(count), e_cnt);
                chk("R5 update", int'(upd_evt), int'(e_upd));
            end
            chk("R6 flag0", int'(cmp_flag[0]), int'((e_cnt == c0) && allow(mode, e_dn)));
            chk("R6 flag1", int'(cmp_flag[1]), int'((e_cnt == c1) && allow(mode, e_dn)));
            rd(2'd0, v);
            chk("R8 dir view", int'(v[4]), int'(e_dir));
        end
    endtask

    initial begin
        logic [15:0] v;
        int pulses;

        do_reset();
        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", int'(v), 0);
        rd(2'd1, v); chk("R1 reload", int'(v), 16'hFFFF);
        rd(2'd2, v); chk("R1 count", int'(v), 0);
        chk("R1 update", int'(upd_evt), 0);
        chk("R1 flags", int'(cmp_flag), 0);

        // R12 unused bits
        wr(2'd0, 16'hFC06);
        rd(2'd0, v); chk("R12 unused bits", int'(v), 0);

        // R2 sampling enable rates
        for (int d = 0; d < 3; d++) begin
            wr(2'd0, 16'(d << 8));
            pulses = 0;
            for (int i = 0; i < 16; i++) begin
                if (smp_en) pulses++;
                step();
            end
            chk("R2 pulses", pulses, 16 >> d);
        end

        // R3 R4 R5 R6 R8 sweeps
        for (int a = 1; a <= 6; a++) begin
            sweep(0, 1'b0, a, 2 * (a + 1) + 1);
            sweep(0, 1'b1, a, 2 * (a + 1) + 1);
            for (int md = 1; md <= 3; md++) begin
                sweep(md, 1'b0, a, 4 * a + 1);
            end
        end

        // R7 forbidden mode change while running
        do_reset();
        wr(2'd1, 16'd5);
        wr(2'd0, 16'h0001);
        step(); step();
        wr(2'd0, 16'h0021);
        rd(2'd0, v); chk("R7 ctrl kept", int'(v), 16'h0001);
        chk("R7 count", int'(count), 3);
        step(); step();
        chk("R7 top", int'(count), 5);
        step();
        chk("R7 edge wrap", int'(count), 0);
        chk("R7 edge wrap update", int'(upd_evt), 1);

        // R9 one-pulse
        do_reset();
        wr(2'd1, 16'd3);
        wr(2'd0, 16'h0009);
        for (int k = 1; k <= 4; k++) begin
            step();
            chk("R9 count", int'(count), k % 4);
        end
        chk("R9 update", int'(upd_evt), 1);
        rd(2'd0, v); chk("R9 run cleared", int'(v[0]), 0);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R9 halted count", int'(count), 0);
            chk("R9 no update", int'(upd_evt), 0);
        end

        // R10 direct reload
        do_reset();
        wr(2'd1, 16'd10);
        wr(2'd0, 16'h0001);
        step(); step(); step();
        wr(2'd1, 16'd5);
        chk("R10 count", int'(count), 4);
        step();
        chk("R10 count", int'(count), 5);
        step();
        chk("R10 early wrap", int'(count), 0);
        chk("R10 update", int'(upd_evt), 1);

        // R11 shadowed reload
        do_reset();
        wr(2'd1, 16'd10);
        wr(2'd0, 16'h0081);
        step(); step(); step();
        wr(2'd1, 16'd5);
        rd(2'd1, v); chk("R11 shadow readback", int'(v), 5);
        step(); step();
        chk("R11 old limit kept", int'(count), 6);
        for (int k = 7; k <= 11; k++) step();
        chk("R11 wrap at old limit", int'(count), 0);
        chk("R11 update", int'(upd_evt), 1);
        for (int k = 12; k <= 16; k++) step();
        chk("R11 new limit top", int'(count), 5);
        step();
        chk("R11 wrap at new limit", int'(count), 0);
        chk("R11 update new", int'(upd_evt), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule